// File: doc/BRIEF.md
# SPI Master/Slave Serial Port

This block is an 8-bit full-duplex synchronous serial port. It can run as bus master and drive the serial clock itself, or as a slave and follow a clock from outside. One shift register sends a byte and receives a byte at the same time, most significant bit first. A write to the port when it is idle loads the shift register, and in master mode that write also starts the transfer. The received byte goes into a holding buffer, so the next byte can start shifting before software reads the previous one.

Static configuration inputs choose master or slave, the idle level of the clock, which clock edge launches output data, and whether a master samples input data in the middle or at the end of each bit. They also choose the master clock rate and whether a slave uses its select input. Three status flags are visible at the register interface: a buffer-full flag, a one-cycle interrupt pulse, and sticky flags for write collision and receive overflow. In slave mode the clock, select and data inputs pass through two-flop synchronisers before edges are detected.

Top module: `spi_port`

## Requirements
- R1: In master mode one transfer sends the written byte on `sdo` and receives a byte from `sdi`, 8 bits each way, most significant bit first.
- R2: `sck_o` rests at `cfg_cpol` when idle. With `cfg_cpha`=0 the first bit is on `sdo` before the first edge, input is sampled on leading edges and output changes on trailing edges. With `cfg_cpha`=1 output changes on leading edges and input is sampled on trailing edges.
- R3: In master mode with `cfg_late`=1, input is sampled at the end of each bit's output window, which is the next launching edge. The last bit is sampled on the final clock edge.
- R4: `cfg_rate` sets the master half period: 0 gives 2 system clocks, 1 gives 8, 2 gives 32, and 3 advances one half period for each `tmr_tick` pulse.
- R5: When the eighth bit has been sampled and the buffer is free, the byte goes into the buffer on `rd_data`. At the same time `buf_full` rises and `irq` pulses for one cycle. `buf_full` stays set until a cycle with `rd_en`=1 clears it.
- R6: A new transfer may run while `buf_full` is set. If it completes while the buffer is still full, the buffer keeps its old byte, no `irq` is raised, and `ovf` is set. `ovf` stays set until `ovf_clr`.
- R7: A write while a transfer is active is dropped and does not change the byte being sent. It sets `wcol`, which stays set until `wcol_clr`.
- R8: In slave mode (`cfg_master`=0) the port shifts on edges of `sck_i`, for both phase settings, sending the loaded byte and receiving from `sdi`.
- R9: In slave mode with `cfg_ss_en`=1, a high `ss_n` drops `sdo_oe` to 0 and discards any partial byte. With `cfg_ss_en`=0, `ss_n` has no effect and `sdo_oe` stays 1.
- R10: After reset `buf_full`, `irq`, `wcol` and `ovf` are 0, `sck_o` equals `cfg_cpol`, and `sdo_oe` is 1 in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0 = launch on trailing edge, 1 = launch on leading edge |
| cfg_late | input | 1 | Master only: sample input at the end of the bit |
| cfg_rate | input | 2 | Master clock source select |
| cfg_ss_en | input | 1 | Slave honours `ss_n` |
| tmr_tick | input | 1 | External timer strobe for rate 3 |
| wr_en | input | 1 | Write strobe for transmit data |
| wr_data | input | 8 | Transmit byte |
| rd_en | input | 1 | Read strobe, clears `buf_full` |
| rd_data | output | 8 | Receive buffer |
| wcol_clr | input | 1 | Clears the collision flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| irq | output | 1 | One-cycle pulse when a byte is accepted |
| wcol | output | 1 | Sticky write-collision flag |
| ovf | output | 1 | Sticky receive-overflow flag |
| sck_o | output | 1 | Master serial clock |
| sck_i | input | 1 | Slave serial clock |
| ss_n | input | 1 | Slave select, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
The bench runs every clock mode against a model peer. Each run returns a byte that differs from the one sent, so a design that shifts least significant bit first, samples on the wrong edge or sends the response back in place of the written byte shows a wrong received or sent byte. In late-sample runs the peer changes each bit only at the mid-window edge, so a master that still samples in the middle picks up the previous bit. Further runs write during an active transfer, let a second byte complete into a full buffer, and cut a slave transfer short with select. A design that lets a colliding write through, lets an overflow overwrite the buffer, or keeps counting a partial byte then sends or receives a corrupted byte or raises an interrupt that was not expected.

// File: rtl/spi_pkg.sv
package spi_pkg;

    localparam int DATA_W   = 8;
    localparam int MAX_HALF = 32;

    typedef enum logic [1:0] {
        RATE_DIV4  = 2'd0,
        RATE_DIV16 = 2'd1,
        RATE_DIV64 = 2'd2,
        RATE_TIMER = 2'd3
    } rate_e;

    typedef struct packed {
        logic  master;
        logic  cpol;
        logic  cpha;
        logic  late;
        rate_e rate;
        logic  ss_en;
    } port_cfg_t;

    // System clocks per serial half period for the divided rates.
    function automatic int unsigned half_len(rate_e r);
        case (r)
            RATE_DIV4:  return 2;
            RATE_DIV16: return 8;
            default:    return MAX_HALF;
        endcase
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] init,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= init;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
    import spi_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  rate_e rate,
    input  logic  tmr_tick,
    output logic  half_tick
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit = CW'(half_len(rate) - 1);

    always_comb begin
        if (rate == RATE_TIMER) half_tick = run && tmr_tick;
        else                    half_tick = run && (cnt == limit);
    end

    always_ff @(posedge clk) begin
        if (rst || !run)              cnt <= '0;
        else if (rate != RATE_TIMER)  cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int  DW = 8,
    localparam int EW = $clog2(2*DW),
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpha,
    input  logic          late_en,
    input  logic          edge_ev,
    input  logic          sdi_bit,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          clear,
    output logic [EW-1:0] edge_idx,
    output logic          sdo_bit,
    output logic          done,
    output logic [DW-1:0] shreg_q
);
    localparam logic [EW-1:0] LAST = EW'(2*DW - 1);

    logic [BW-1:0] bcnt;
    logic [DW-1:0] shreg;
    logic          leading, launch, sample_now, launch_now;

    // Even edge indices leave the idle level, odd ones return to it.
    always_comb begin
        leading = ~edge_idx[0];
        launch  = cpha ? leading : ~leading;
        if (late_en)
            sample_now = (launch && !(cpha && edge_idx == '0)) || (cpha && edge_idx == LAST);
        else
            sample_now = ~launch;
        launch_now = launch && (edge_idx != LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            sdo_bit  <= 1'b0;
            edge_idx <= '0;
            bcnt     <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                shreg    <= load_data;
                sdo_bit  <= load_data[DW-1];
                edge_idx <= '0;
                bcnt     <= '0;
            end else if (clear) begin
                edge_idx <= '0;
                bcnt     <= '0;
            end else if (edge_ev) begin
                edge_idx <= edge_idx + 1'b1;
                if (sample_now) begin
                    shreg <= {shreg[DW-2:0], sdi_bit};
                    bcnt  <= bcnt + 1'b1;
                    if (bcnt == BW'(DW-1)) done <= 1'b1;
                end
                if (launch_now) sdo_bit <= sample_now ? shreg[DW-2] : shreg[DW-1];
            end
        end
    end

    assign shreg_q = shreg;
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_pkg::*;
#(
    parameter int DW          = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_master,
    input  logic          cfg_cpol,
    input  logic          cfg_cpha,
    input  logic          cfg_late,
    input  logic [1:0]    cfg_rate,
    input  logic          cfg_ss_en,
    input  logic          tmr_tick,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          wcol_clr,
    input  logic          ovf_clr,
    output logic          buf_full,
    output logic          irq,
    output logic          wcol,
    output logic          ovf,
    output logic          sck_o,
    input  logic          sck_i,
    input  logic          ss_n,
    input  logic          sdi,
    output logic          sdo,
    output logic          sdo_oe
);
    localparam int EW = $clog2(2*DW);
    localparam int CW = $clog2(MAX_HALF) + 1;
    localparam logic [EW-1:0] LAST = EW'(2*DW - 1);

    port_cfg_t cfg;
    assign cfg = '{master: cfg_master, cpol: cfg_cpol, cpha: cfg_cpha, late: cfg_late,
                   rate: rate_e'(cfg_rate), ss_en: cfg_ss_en};

    // Slave-side pin synchronisers; the clock resets to its idle level.
    logic [2:0] pins_s;
    logic       sck_s, ss_s, sdi_s, sck_d;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .init ({cfg_cpol, 1'b1, 1'b0}),
        .d    ({sck_i, ss_n, sdi}),
        .q    (pins_s)
    );
    assign {sck_s, ss_s, sdi_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= cfg_cpol;
        else     sck_d <= sck_s;
    end

    logic          busy, sck_r, half_tick, active, start, edge_ev, selected, clear;
    logic          done, sdo_bit;
    logic [EW-1:0] edge_idx;
    logic [DW-1:0] shreg_q, rx_buf;

    assign selected = !cfg.ss_en || !ss_s;
    assign active   = cfg.master ? busy : (edge_idx != '0);
    assign start    = wr_en && !active && cfg.master;
    assign clear    = !cfg.master && !selected;
    assign edge_ev  = cfg.master ? (busy && half_tick) : (selected && (sck_s != sck_d));

    spi_clkgen #(.CW(CW)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .rate      (cfg.rate),
        .tmr_tick  (tmr_tick),
        .half_tick (half_tick)
    );

    // Master clock: one toggle per half period, 2*DW edges per byte.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            sck_r <= 1'b0;
        end else if (start) begin
            busy  <= 1'b1;
            sck_r <= cfg.cpol;
        end else if (busy && half_tick) begin
            sck_r <= ~sck_r;
            if (edge_idx == LAST) busy <= 1'b0;
        end
    end

    spi_shifter #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .cpha      (cfg.cpha),
        .late_en   (cfg.master && cfg.late),
        .edge_ev   (edge_ev),
        .sdi_bit   (cfg.master ? sdi : sdi_s),
        .load      (wr_en && !active),
        .load_data (wr_data),
        .clear     (clear),
        .edge_idx  (edge_idx),
        .sdo_bit   (sdo_bit),
        .done      (done),
        .shreg_q   (shreg_q)
    );

    // Receive buffer and status flags; a same-cycle read frees the buffer.
    logic full_eff;
    assign full_eff = buf_full && !rd_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_buf   <= '0;
            buf_full <= 1'b0;
            irq      <= 1'b0;
            wcol     <= 1'b0;
            ovf      <= 1'b0;
        end else begin
            irq <= done && !full_eff;
            if (done && !full_eff) begin
                rx_buf   <= shreg_q;
                buf_full <= 1'b1;
            end else if (rd_en) begin
                buf_full <= 1'b0;
            end
            if (done && full_eff) ovf <= 1'b1;
            else if (ovf_clr)     ovf <= 1'b0;
            if (wr_en && active)  wcol <= 1'b1;
            else if (wcol_clr)    wcol <= 1'b0;
        end
    end

    assign rd_data = rx_buf;
    assign sck_o   = busy ? sck_r : cfg.cpol;
    assign sdo     = sdo_bit;
    assign sdo_oe  = cfg.master || selected;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          irq,
    input logic          buf_full,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic          wcol,
    input logic          wcol_clr,
    input logic          ovf,
    input logic          ovf_clr
);
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);  // R5
    AST_IRQ_WITH_FULL: assert property (@(posedge clk) disable iff (rst) irq |-> buf_full);  // R5
    AST_FULL_UNTIL_READ: assert property (@(posedge clk) disable iff (rst) buf_full && !rd_en |=> buf_full);  // R5
    AST_BUF_HELD: assert property (@(posedge clk) disable iff (rst) buf_full && !rd_en |=> $stable(rd_data));  // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) ovf && !ovf_clr |=> ovf);  // R6
    AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (rst) wcol && !wcol_clr |=> wcol);  // R7
endmodule

bind spi_port spi_port_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .buf_full (buf_full),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .wcol     (wcol),
    .wcol_clr (wcol_clr),
    .ovf      (ovf),
    .ovf_clr  (ovf_clr)
);

// File: tb/tb_spi_port.sv
module tb_spi_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_late = 1'b0, cfg_ss_en = 1'b0;
    logic [1:0] cfg_rate = 2'd0;
    logic       tmr_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       mon_rd = 1'b0, drv_rd = 1'b0, rd_en;
    logic [7:0] rd_data;
    logic       wcol_clr = 1'b0, ovf_clr = 1'b0;
    logic       buf_full, irq, wcol, ovf, sck_o, sdo, sdo_oe;
    logic       sck_i = 1'b0, ss_n = 1'b1;
    logic       bs_sdi = 1'b0, bm_sdi = 1'b0, sdi;

    assign rd_en = mon_rd | drv_rd;
    assign sdi   = cfg_master ? bs_sdi : bm_sdi;

    always #4 clk = ~clk;

    spi_port dut (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_late(cfg_late), .cfg_rate(cfg_rate), .cfg_ss_en(cfg_ss_en), .tmr_tick(tmr_tick),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .wcol_clr(wcol_clr), .ovf_clr(ovf_clr), .buf_full(buf_full), .irq(irq), .wcol(wcol),
        .ovf(ovf), .sck_o(sck_o), .sck_i(sck_i), .ss_n(ss_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    int    checks = 0, errors = 0;
    bit    finished = 1'b0;
    bit    auto_read = 1'b1;
    string cur_req = "R1";
    logic [7:0] exp_q [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Timer strobe every 5 system clocks.
    int tcnt = 0;
    initial forever begin
        @(negedge clk);
        tcnt     = (tcnt == 4) ? 0 : tcnt + 1;
        tmr_tick = (tcnt == 0);
    end

    int cyc = 0;
    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Scoreboard monitor: each irq pops one expected received byte.
    initial forever begin
        @(negedge clk);
        mon_rd = 1'b0;
        if (irq && !rst) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, {cur_req, " unexpected irq"}, rd_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, {cur_req, " received byte"}, rd_data, e);
            end
            if (auto_read) mon_rd = 1'b1;
        end
    end

    // Peer slave model for master-mode transfers.
    bit         bs_on = 1'b0;
    logic       bs_prev = 1'b0;
    logic [7:0] bs_byte = 8'h00, bs_cap = 8'h00;
    int         be = 0, last_cyc = 0, hp_min = 0, hp_max = 0;

    initial forever begin
        @(negedge clk);
        if (bs_on && sck_o !== bs_prev) begin
            bit lead, launch;
            lead   = (be % 2 == 0);
            launch = cfg_cpha ? lead : !lead;
            if (!launch) bs_cap = {bs_cap[6:0], sdo};
            if (!cfg_late) begin
                if (launch && be != 15) bs_sdi = bs_byte[cfg_cpha ? 7 - be/2 : 7 - (be+1)/2];
            end else begin
                if (!cfg_cpha && !launch)            bs_sdi = bs_byte[7 - be/2];
                else if (cfg_cpha && !launch && be < 15) bs_sdi = bs_byte[7 - (be-1)/2];
                else if (cfg_cpha && be == 14)       bs_sdi = bs_byte[0];
            end
            if (be > 0) begin
                if (cyc - last_cyc < hp_min) hp_min = cyc - last_cyc;
                if (cyc - last_cyc > hp_max) hp_max = cyc - last_cyc;
            end
            last_cyc = cyc;
            be++;
        end
        bs_prev = sck_o;
    end

    // Driver: one master transfer against the peer model.
    task automatic mxfer(input logic [7:0] tx, input logic [7:0] rsp, input bit expect_irq,
                         input bit collide, input int hp_exp);
        bs_byte = rsp; be = 0; bs_cap = 8'h00; hp_min = 1000; hp_max = 0;
        bs_sdi  = cfg_late ? ~rsp[7] : rsp[7];
        if (expect_irq) exp_q.push_back(rsp);
        @(negedge clk);
        wr_en = 1'b1; wr_data = tx; bs_on = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (collide) begin
            wait (be >= 5);
            @(negedge clk);
            wr_en = 1'b1; wr_data = 8'hFF;
            @(negedge clk);
            wr_en = 1'b0;
        end
        wait (be == 16);
        repeat (4) @(negedge clk);
        bs_on = 1'b0;
        chk(bs_cap == tx, {cur_req, " sent byte"}, bs_cap, tx);
        chk(sck_o == cfg_cpol, "R2 idle clock level", sck_o, cfg_cpol);
        if (hp_exp > 0)
            chk(hp_min == hp_exp && hp_max == hp_exp, "R4 half period", hp_max, hp_exp);
    endtask

    // Driver: bench acts as master for slave-mode transfers.
    task automatic sxfer(input logic [7:0] ld, input logic [7:0] mb, input bit use_ss, input int n_edges);
        logic [7:0] cap;
        cap   = 8'h00;
        sck_i = cfg_cpol;
        @(negedge clk);
        wr_en = 1'b1; wr_data = ld;
        @(negedge clk);
        wr_en = 1'b0;
        if (n_edges == 16) exp_q.push_back(mb);
        bm_sdi = mb[7];
        if (use_ss) ss_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int e = 0; e < n_edges; e++) begin
            bit lead, launch;
            lead   = (e % 2 == 0);
            launch = cfg_cpha ? lead : !lead;
            if (!launch) cap = {cap[6:0], sdo};
            sck_i = ~sck_i;
            if (launch && e != 15) bm_sdi = mb[cfg_cpha ? 7 - e/2 : 7 - (e+1)/2];
            repeat (8) @(negedge clk);
        end
        if (n_edges == 16) chk(cap == ld, "R8 slave sent byte", cap, ld);
        repeat (4) @(negedge clk);
        if (use_ss) ss_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(buf_full == 1'b0, "R10 buf_full", buf_full, 0);
        chk(irq == 1'b0, "R10 irq", irq, 0);
        chk(wcol == 1'b0 && ovf == 1'b0, "R10 sticky flags", {wcol, ovf}, 0);
        chk(sck_o == 1'b0, "R10 clock idle", sck_o, 0);
        chk(sdo_oe == 1'b1, "R10 output enable", sdo_oe, 1);

        // R1 R2 R4: the four clock modes and the rates
        cur_req = "R1";
        mxfer(8'hA5, 8'h3C, 1, 0, 2);
        chk(buf_full == 1'b0, "R5 read clears buf_full", buf_full, 0);
        cur_req = "R2";
        cfg_cpol = 1'b1; cfg_rate = 2'd1;
        mxfer(8'h96, 8'hC3, 1, 0, 8);
        cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_rate = 2'd2;
        mxfer(8'h5A, 8'h81, 1, 0, 32);
        cfg_cpol = 1'b1; cfg_rate = 2'd3;
        mxfer(8'hE7, 8'h18, 1, 0, 5);

        // R3 late sampling in both phases
        cur_req = "R3";
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_rate = 2'd0; cfg_late = 1'b1;
        mxfer(8'h0F, 8'hB2, 1, 0, 2);
        cfg_cpha = 1'b1;
        mxfer(8'hF0, 8'h4D, 1, 0, 2);
        cfg_late = 1'b0; cfg_cpha = 1'b0;

        // R7 write collision
        cur_req = "R7";
        mxfer(8'hC6, 8'h29, 1, 1, 0);
        chk(wcol == 1'b1, "R7 wcol set", wcol, 1);
        repeat (10) @(negedge clk);
        chk(wcol == 1'b1, "R7 wcol sticky", wcol, 1);
        wcol_clr = 1'b1; @(negedge clk); wcol_clr = 1'b0; @(negedge clk);
        chk(wcol == 1'b0, "R7 wcol cleared", wcol, 0);

        // R6 double buffering and overflow
        cur_req = "R6";
        auto_read = 1'b0;
        mxfer(8'h44, 8'h11, 1, 0, 0);
        mxfer(8'h55, 8'h22, 0, 0, 0);
        chk(ovf == 1'b1, "R6 overflow set", ovf, 1);
        chk(rd_data == 8'h11, "R6 buffer kept", rd_data, 8'h11);
        chk(buf_full == 1'b1, "R6 still full", buf_full, 1);
        drv_rd = 1'b1; @(negedge clk); drv_rd = 1'b0; @(negedge clk);
        chk(buf_full == 1'b0, "R5 rd_en clears buf_full", buf_full, 0);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; @(negedge clk);
        chk(ovf == 1'b0, "R6 overflow cleared", ovf, 0);
        auto_read = 1'b1;

        // R8 slave mode, both phases
        cur_req = "R8";
        ss_n = 1'b1; cfg_ss_en = 1'b1; cfg_master = 1'b0;
        repeat (4) @(negedge clk);
        sxfer(8'h3B, 8'h9E, 1, 16);
        cfg_cpha = 1'b1; cfg_cpol = 1'b1;
        sxfer(8'h64, 8'h2D, 1, 16);

        // R9 select abort discards a partial byte
        cur_req = "R9";
        cfg_cpha = 1'b0; cfg_cpol = 1'b0;
        sxfer(8'hAA, 8'h00, 1, 5);
        chk(sdo_oe == 1'b0, "R9 output released", sdo_oe, 0);
        sxfer(8'h71, 8'hE4, 1, 16);

        // R9 select ignored when disabled
        cfg_ss_en = 1'b0;
        repeat (4) @(negedge clk);
        chk(sdo_oe == 1'b1, "R9 output enabled without select", sdo_oe, 1);
        sxfer(8'h8C, 8'h37, 0, 16);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 0);
        finish_run();
    end
endmodule